// File: doc/BRIEF.md
# Endian-Aware Store Lane Steering

This block sits between a processor's store stage and a 64-bit write data channel. It takes one store request and turns it into one or two write beats. The request carries a byte address, up to four 32-bit register values, an access size and a byte-ordering mode. Each beat carries an aligned address, 64-bit data with every byte on the lane the memory system expects, an 8-bit byte strobe, a last flag and a burst-length field. Three byte orders are supported: little-endian, byte-invariant big-endian and word-invariant big-endian. Word-invariant big-endian forbids misaligned accesses. When such an access is requested, the block raises a one-cycle fault pulse and does not drive any beat.

A single store that crosses a 32-bit boundary is cut at that boundary into two beats, even though the bus is 64 bits wide. A multi-register request packs two consecutive registers into each 64-bit beat, and may carry one pair or two pairs.

Control is a four-state machine:
- `S_IDLE` accepts a request. It moves to `S_FAULT` if the request is illegal, and to `S_FIRST` otherwise.
- `S_FIRST` presents the first beat. On acceptance it moves to `S_SECOND` if a second beat is pending, and back to `S_IDLE` if not.
- `S_SECOND` presents the second beat and returns to `S_IDLE` when that beat is accepted.
- `S_FAULT` pulses the fault output for one cycle and returns to `S_IDLE`.

Top module: `store_lane_steer`

## Requirements
- R1: Little-endian single store. Register byte k (bits 8k+7..8k) goes to lane (addr+k) mod 8. The strobe bit of each written lane is set. Size codes are 0 for byte, 1 for halfword and 2 for word. Order codes are 0 for little-endian, 1 for byte-invariant big-endian and 2 for word-invariant big-endian.
- R2: In order modes 1 and 2, the bytes of a halfword or word are reversed before placement. For example, word 0x76543210 at an 8-byte-aligned address gives lanes 3..0 = 0x10325476 and strobe 0x0F.
- R3: A word store to an address with bit 2 set, and bits 1..0 clear, uses lanes 4..7 with strobe 0xF0 in one beat.
- R4: A single store whose bytes cross a 4-byte boundary is issued as two beats. The first beat has address addr with bits 1..0 cleared. The second beat has that address plus 4. Each byte still sits on lane (its byte address) mod 8. For example, a little-endian word at offset 1 gives strobes 0x0E and 0x10.
- R5: In order mode 2, a byte store uses effective address addr XOR 3 and a halfword store uses addr XOR 2. Lane placement and beat address then follow R1, R2 and R4 with that effective address.
- R6: Any of the following raises `store_fault` for exactly one cycle with no beat issued:
  - order mode 2 with a halfword at an odd address;
  - order mode 2 with a word whose address bits 1..0 are non-zero;
  - size code 3;
  - order code 3;
  - a multi-register request whose address bits 2..0 are non-zero.
- R7: A multi-register request packs register 2b into lanes 0..3 and register 2b+1 into lanes 4..7 of beat b, with strobe 0xFF. Each register is byte-reversed in order modes 1 and 2. Beat 0 uses addr and beat 1 uses addr+8. With one pair there is one beat and the length field is 0; with two pairs there are two beats and the length field is 1. Single stores always report length 0.
- R8: Every data lane whose strobe bit is clear is driven to zero.
- R9: While a beat is valid and not accepted, its address, data, strobe, last flag and length hold steady. `beat_last` is set only on the final beat of a request. `req_ready` is low from acceptance until the final beat or the fault pulse has completed.
- R10: After reset, `req_ready` is 1 and `beat_valid` and `store_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Byte address |
| req_regs | input | 128 | Register k in bits 32k+31..32k; single stores use register 0 |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_order | input | 2 | 0 little, 1 byte-invariant big, 2 word-invariant big, 3 reserved |
| req_multi | input | 1 | Multi-register packed request |
| req_two_pairs | input | 1 | Multi request carries four registers |
| beat_valid | output | 1 | Beat present |
| beat_ready | input | 1 | Beat accepted |
| beat_addr | output | ADDR_W | Aligned beat address |
| beat_data | output | 64 | Lane-steered data |
| beat_strb | output | 8 | Byte strobe |
| beat_last | output | 1 | Final beat of request |
| beat_len | output | 1 | Burst length field (beats minus one) |
| store_fault | output | 1 | Alignment fault pulse |

## Verification
The hardest case to reach is a split store whose two halves straddle a doubleword boundary while the consumer stalls. Here the second beat's lanes wrap back to 0 and its address jumps into the next doubleword, and nothing may move while the beat waits. The bench sweeps every order code, size code and byte offset 0..7 from two bases, one of them just below a 4 KiB line. It holds `beat_ready` low for two cycles on every offset-5 request, so the wrap and the stall occur together.

// File: rtl/stlane_pkg.sv
package stlane_pkg;
    localparam int BEAT_W    = 64;
    localparam int LANES     = BEAT_W / 8;
    localparam int REG_W     = 32;
    localparam int PACK_REGS = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } st_size_e;

    typedef enum logic [1:0] {
        EN_LITTLE   = 2'd0,
        EN_BIG_BYTE = 2'd1,
        EN_BIG_WORD = 2'd2,
        EN_RSVD     = 2'd3
    } st_order_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FIRST  = 2'd1,
        S_SECOND = 2'd2,
        S_FAULT  = 2'd3
    } st_state_e;

    function automatic logic [REG_W-1:0] order_word(input logic [REG_W-1:0] w, input logic sw);
        return sw ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    endfunction
endpackage

// File: rtl/store_lane_pack.sv
module store_lane_pack
    import stlane_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [PACK_REGS*REG_W-1:0] regs_i,
    input  logic [1:0]                 size_i,
    input  logic [1:0]                 order_i,
    input  logic                       multi_i,
    input  logic                       two_pairs_i,
    output logic                       fault_o,
    output logic                       split_o,
    output logic                       len_o,
    output logic [ADDR_W-1:0]          addr0_o,
    output logic [ADDR_W-1:0]          addr1_o,
    output logic [BEAT_W-1:0]          data0_o,
    output logic [BEAT_W-1:0]          data1_o,
    output logic [LANES-1:0]           strb0_o,
    output logic [LANES-1:0]           strb1_o
);
    localparam int WORD_BYTES = REG_W / 8;

    st_size_e         sz;
    st_order_e        ord;
    logic             swap;
    logic [REG_W-1:0] packed_word [PACK_REGS];

    assign sz   = st_size_e'(size_i);
    assign ord  = st_order_e'(order_i);
    assign swap = (ord == EN_BIG_BYTE) || (ord == EN_BIG_WORD);

    // one byte-ordered copy per register for the packed path
    for (genvar g = 0; g < PACK_REGS; g++) begin : g_word
        assign packed_word[g] = order_word(regs_i[REG_W*g +: REG_W], swap);
    end

    always_comb begin
        int              nbytes;
        int              src;
        logic [ADDR_W-1:0] ea;
        logic [2:0]      off;
        logic [2:0]      lane;
        logic [7:0]      bval;

        unique case (sz)
            SZ_BYTE: nbytes = 1;
            SZ_HALF: nbytes = 2;
            SZ_WORD: nbytes = 4;
            default: nbytes = 0;
        endcase

        ea = addr_i;
        if (ord == EN_BIG_WORD && sz == SZ_BYTE)      ea[1:0] = ~addr_i[1:0];
        else if (ord == EN_BIG_WORD && sz == SZ_HALF) ea[1]   = ~addr_i[1];

        data0_o = '0;
        data1_o = '0;
        strb0_o = '0;
        strb1_o = '0;
        split_o = 1'b0;
        len_o   = 1'b0;

        if (multi_i) begin
            fault_o = (addr_i[2:0] != 3'b000) || (ord == EN_RSVD);
            addr0_o = {addr_i[ADDR_W-1:3], 3'b000};
            addr1_o = addr0_o + ADDR_W'(8);
            for (int p = 0; p < PACK_REGS; p++) begin
                if (p < 2) data0_o[REG_W*(p%2) +: REG_W] = packed_word[p];
                else if (two_pairs_i) data1_o[REG_W*(p%2) +: REG_W] = packed_word[p];
            end
            strb0_o = '1;
            strb1_o = two_pairs_i ? '1 : '0;
            split_o = two_pairs_i;
            len_o   = two_pairs_i;
        end else begin
            fault_o = (sz == SZ_RSVD) || (ord == EN_RSVD) ||
                      (ord == EN_BIG_WORD &&
                       ((sz == SZ_HALF && addr_i[0]) || (sz == SZ_WORD && addr_i[1:0] != 2'b00)));
            addr0_o = {ea[ADDR_W-1:2], 2'b00};
            addr1_o = addr0_o + ADDR_W'(WORD_BYTES);
            for (int k = 0; k < WORD_BYTES; k++) begin
                if (k < nbytes) begin
                    src  = swap ? (nbytes - 1 - k) : k;
                    bval = regs_i[8*src +: 8];
                    off  = {1'b0, ea[1:0]} + 3'(k);
                    lane = {off[2] ? ~ea[2] : ea[2], off[1:0]};
                    if (!off[2]) begin
                        data0_o[8*int'(lane) +: 8] = bval;
                        strb0_o[lane]              = 1'b1;
                    end else begin
                        data1_o[8*int'(lane) +: 8] = bval;
                        strb1_o[lane]              = 1'b1;
                        split_o                    = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/store_lane_ctrl.sv
module store_lane_ctrl
    import stlane_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              in_fault_i,
    input  logic              in_split_i,
    input  logic              in_len_i,
    input  logic [ADDR_W-1:0] in_addr0_i,
    input  logic [ADDR_W-1:0] in_addr1_i,
    input  logic [BEAT_W-1:0] in_data0_i,
    input  logic [BEAT_W-1:0] in_data1_i,
    input  logic [LANES-1:0]  in_strb0_i,
    input  logic [LANES-1:0]  in_strb1_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [ADDR_W-1:0] out_addr_o,
    output logic [BEAT_W-1:0] out_data_o,
    output logic [LANES-1:0]  out_strb_o,
    output logic              out_last_o,
    output logic              out_len_o,
    output logic              fault_o
);
    st_state_e         state, nxt;
    logic              h_split, h_len;
    logic [ADDR_W-1:0] h_addr0, h_addr1;
    logic [BEAT_W-1:0] h_data0, h_data1;
    logic [LANES-1:0]  h_strb0, h_strb1;
    logic              take;

    assign take = (state == S_IDLE) && req_valid_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            h_split <= 1'b0;
            h_len   <= 1'b0;
            h_addr0 <= '0;
            h_addr1 <= '0;
            h_data0 <= '0;
            h_data1 <= '0;
            h_strb0 <= '0;
            h_strb1 <= '0;
        end else begin
            state <= nxt;
            if (take) begin
                h_split <= in_split_i;
                h_len   <= in_len_i;
                h_addr0 <= in_addr0_i;
                h_addr1 <= in_addr1_i;
                h_data0 <= in_data0_i;
                h_data1 <= in_data1_i;
                h_strb0 <= in_strb0_i;
                h_strb1 <= in_strb1_i;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (req_valid_i) nxt = in_fault_i ? S_FAULT : S_FIRST;
            S_FIRST:  if (out_ready_i) nxt = h_split ? S_SECOND : S_IDLE;
            S_SECOND: if (out_ready_i) nxt = S_IDLE;
            S_FAULT:  nxt = S_IDLE;
        endcase
    end

    always_comb begin
        req_ready_o = (state == S_IDLE);
        out_valid_o = (state == S_FIRST) || (state == S_SECOND);
        fault_o     = (state == S_FAULT);
        out_addr_o  = (state == S_SECOND) ? h_addr1 : h_addr0;
        out_data_o  = (state == S_SECOND) ? h_data1 : h_data0;
        out_strb_o  = (state == S_SECOND) ? h_strb1 : h_strb0;
        out_last_o  = (state == S_SECOND) || ((state == S_FIRST) && !h_split);
        out_len_o   = out_valid_o && h_len;
    end

    logic [BEAT_W-1:0] lane_mask;
    always_comb begin
        for (int i = 0; i < LANES; i++) lane_mask[8*i +: 8] = {8{out_strb_o[i]}};
    end

    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_addr_o) &&
        $stable(out_data_o) && $stable(out_strb_o) && $stable(out_last_o));
    a_r8_dead_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_data_o & ~lane_mask) == '0);
    a_r6_fault_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o && req_ready_o);
    a_r6_fault_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !out_valid_o);
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !req_ready_o);
    a_r9_last_frees: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_ready_i && out_last_o |=> req_ready_o);
    a_r1_strobe_present: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> out_strb_o != '0);
endmodule

// File: rtl/store_lane_steer.sv
module store_lane_steer
    import stlane_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [PACK_REGS*REG_W-1:0] req_regs,
    input  logic [1:0]                 req_size,
    input  logic [1:0]                 req_order,
    input  logic                       req_multi,
    input  logic                       req_two_pairs,
    output logic                       beat_valid,
    input  logic                       beat_ready,
    output logic [ADDR_W-1:0]          beat_addr,
    output logic [BEAT_W-1:0]          beat_data,
    output logic [LANES-1:0]           beat_strb,
    output logic                       beat_last,
    output logic                       beat_len,
    output logic                       store_fault
);
    logic              p_fault, p_split, p_len;
    logic [ADDR_W-1:0] p_addr0, p_addr1;
    logic [BEAT_W-1:0] p_data0, p_data1;
    logic [LANES-1:0]  p_strb0, p_strb1;

    store_lane_pack #(.ADDR_W(ADDR_W)) u_pack (
        .addr_i     (req_addr),
        .regs_i     (req_regs),
        .size_i     (req_size),
        .order_i    (req_order),
        .multi_i    (req_multi),
        .two_pairs_i(req_two_pairs),
        .fault_o    (p_fault),
        .split_o    (p_split),
        .len_o      (p_len),
        .addr0_o    (p_addr0),
        .addr1_o    (p_addr1),
        .data0_o    (p_data0),
        .data1_o    (p_data1),
        .strb0_o    (p_strb0),
        .strb1_o    (p_strb1)
    );

    store_lane_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid_i(req_valid),
        .req_ready_o(req_ready),
        .in_fault_i (p_fault),
        .in_split_i (p_split),
        .in_len_i   (p_len),
        .in_addr0_i (p_addr0),
        .in_addr1_i (p_addr1),
        .in_data0_i (p_data0),
        .in_data1_i (p_data1),
        .in_strb0_i (p_strb0),
        .in_strb1_i (p_strb1),
        .out_valid_o(beat_valid),
        .out_ready_i(beat_ready),
        .out_addr_o (beat_addr),
        .out_data_o (beat_data),
        .out_strb_o (beat_strb),
        .out_last_o (beat_last),
        .out_len_o  (beat_len),
        .fault_o    (store_fault)
    );

    // R4: the second beat of a split always sits one word or one doubleword above the first
    a_r4_second_beat_above: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && !beat_last |=> beat_valid &&
        (beat_addr == $past(beat_addr) + ADDR_W'(4) || beat_addr == $past(beat_addr) + ADDR_W'(8)));
endmodule

// File: tb/tb_store_lane_steer.sv
`timescale 1ns/1ps
module tb_store_lane_steer;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [127:0]  req_regs = '0;
    logic [1:0]    req_size = '0;
    logic [1:0]    req_order = '0;
    logic          req_multi = 1'b0;
    logic          req_two_pairs = 1'b0;
    logic          beat_valid;
    logic          beat_ready = 1'b0;
    logic [AW-1:0] beat_addr;
    logic [63:0]   beat_data;
    logic [7:0]    beat_strb;
    logic          beat_last;
    logic          beat_len;
    logic          store_fault;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    store_lane_steer #(.ADDR_W(AW)) dut (.*);

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog act %0d exp <150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act %h exp %h", tag, what, act, expv);
        end
    endtask

    // expected beats computed from byte addresses
    task automatic do_req(input logic [AW-1:0] a, input logic [127:0] regs, input int sz,
                          input int md, input bit multi, input bit pairs, input int stall);
        bit          flt;
        int          nb;
        logic [AW-1:0] ea [2];
        logic [63:0] ed [2];
        logic [7:0]  es [2];
        bit          elen;
        string       tag;
        int          n, e, bt, ln;
        logic [7:0]  bv;
        bit          sw;

        sw = (md == 1) || (md == 2);
        ed[0] = '0; ed[1] = '0; es[0] = '0; es[1] = '0;
        elen = 1'b0;
        if (multi) begin
            flt = (a % 8 != 0) || md == 3;
            nb = pairs ? 2 : 1;
            elen = pairs;
            ea[0] = a; ea[1] = a + 8;
            for (int p = 0; p < 4; p++) begin
                for (int j = 0; j < 4; j++) begin
                    bv = regs[32*p + 8*(sw ? 3 - j : j) +: 8];
                    if (p / 2 < nb) begin
                        ed[p/2][32*(p%2) + 8*j +: 8] = bv;
                        es[p/2][4*(p%2) + j] = 1'b1;
                    end
                end
            end
            tag = flt ? "R6" : "R7";
        end else begin
            n = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
            flt = (md == 3) || (sz == 3) ||
                  (md == 2 && ((sz == 1 && a % 2 != 0) || (sz == 2 && a % 4 != 0)));
            e = int'(a);
            if (md == 2 && sz == 0) e = e ^ 3;
            if (md == 2 && sz == 1) e = e ^ 2;
            ea[0] = AW'(e - e % 4); ea[1] = ea[0] + 4;
            nb = 1;
            for (int k = 0; k < n; k++) begin
                bv = regs[8*(sw ? n - 1 - k : k) +: 8];
                ln = (e + k) % 8;
                bt = ((e % 4) + k >= 4) ? 1 : 0;
                if (bt == 1) nb = 2;
                ed[bt][8*ln +: 8] = bv;
                es[bt][ln] = 1'b1;
            end
            if (flt) tag = "R6";
            else if (nb == 2) tag = "R4";
            else if (md == 2 && sz < 2) tag = "R5";
            else if (md != 0) tag = "R2";
            else if (sz == 2 && a[2]) tag = "R3";
            else tag = "R1";
        end

        chk(req_ready == 1'b1, "R9", "ready before request", {127'd0, req_ready}, 128'd1);
        req_addr = a; req_regs = regs; req_size = 2'(sz); req_order = 2'(md);
        req_multi = multi; req_two_pairs = pairs; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        if (flt) begin
            chk(store_fault && !beat_valid, "R6", "fault pulse",
                {126'd0, store_fault, beat_valid}, 128'd2);
            @(posedge clk); @(negedge clk);
            chk(!store_fault && req_ready, "R6", "fault ends",
                {126'd0, store_fault, req_ready}, 128'd1);
        end else begin
            for (int b = 0; b < nb; b++) begin
                for (int s = 0; s < stall; s++) begin
                    chk(beat_valid && !req_ready && beat_addr == ea[b] && beat_data == ed[b] &&
                        beat_strb == es[b], "R9", "stalled beat held",
                        {beat_data, beat_addr, 24'd0, beat_strb}, {ed[b], ea[b], 24'd0, es[b]});
                    @(posedge clk); @(negedge clk);
                end
                chk(beat_valid && beat_addr == ea[b] && beat_strb == es[b], tag, "addr/strb",
                    {beat_addr, 24'd0, beat_strb}, {ea[b], 24'd0, es[b]});
                chk(beat_data == ed[b], tag, "data", beat_data, ed[b]);
                chk((beat_data & ~{ {8{es[b][7]}},{8{es[b][6]}},{8{es[b][5]}},{8{es[b][4]}},
                                    {8{es[b][3]}},{8{es[b][2]}},{8{es[b][1]}},{8{es[b][0]}} }) == 64'd0,
                    "R8", "dead lanes", beat_data, ed[b]);
                chk(beat_last == (b == nb - 1) && beat_len == elen, "R9", "last/len",
                    {126'd0, beat_last, beat_len}, {126'd0, b == nb - 1, elen});
                beat_ready = 1'b1;
                @(posedge clk); @(negedge clk);
                beat_ready = 1'b0;
            end
            chk(req_ready && !beat_valid, "R9", "idle after request",
                {126'd0, req_ready, beat_valid}, 128'd2);
        end
    endtask

    initial begin
        logic [127:0] pat [2];
        logic [AW-1:0] base [2];
        pat[0] = {32'h0F0E0D0C, 32'h0B0A0908, 32'h07060504, 32'h76543210};
        pat[1] = {32'hDEADBEEF, 32'h13579BDF, 32'h2468ACE0, 32'hA5C3E18F};
        base[0] = 32'h0000_1000;
        base[1] = 32'h0000_0FF8;

        repeat (3) @(negedge clk);
        chk(req_ready && !beat_valid && !store_fault, "R10", "in reset",
            {125'd0, req_ready, beat_valid, store_fault}, 128'd4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !beat_valid && !store_fault, "R10", "after reset",
            {125'd0, req_ready, beat_valid, store_fault}, 128'd4);

        for (int bi = 0; bi < 2; bi++)
            for (int pi = 0; pi < 2; pi++)
                for (int md = 0; md < 4; md++)
                    for (int sz = 0; sz < 4; sz++)
                        for (int off = 0; off < 8; off++)
                            do_req(base[bi] + AW'(off), pat[pi], sz, md, 1'b0, 1'b0,
                                   (off == 5) ? 2 : 0);

        for (int md = 0; md < 4; md++)
            for (int pr = 0; pr < 2; pr++) begin
                do_req(32'h0000_1000, pat[0], 2, md, 1'b1, pr[0], pr * 2);
                do_req(32'h0000_2FF8, pat[1], 2, md, 1'b1, pr[0], 0);
                do_req(32'h0000_1004, pat[0], 2, md, 1'b1, pr[0], 0);
                do_req(32'h0000_1002, pat[1], 2, md, 1'b1, pr[0], 0);
            end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule